// File: doc/BRIEF.md
# Wireless Power Receiver Contract Sequencer

This block runs the control flow of an inductive power receiver, from the moment a transmitter ping arrives until power transfer ends. Once a ping is seen, it asks a packet modulator to send the three start-up packets in a fixed order. It then tries a proprietary high-power handshake and records the power mode that results. After that it enables the output and watches a set of comparator fault flags. When a flag trips, it turns the output off and asks for an end-of-transfer packet whose reason byte names the cause.

Each packet request is a level with a type code. It stays up until the modulator acknowledges it. Analog sensing and bit-level modulation are handled outside this block. The block only consumes the digital flags those circuits produce and emits requests.

Top module: `wpt_contract_seq`

## Requirements
- R1: During and after reset, with no ping seen, `pkt_req`, `out_en` and `mode_hp` are 0 and `reason` is 0x00.
- R2: When `ping_evt` arrives in idle with neither `flt_adapter` nor `flt_ctrl_high` set, the block requests packet types 1 (signal strength), 2 (configuration) and 3 (identification) in that order. Each request holds its type until a cycle with `pkt_ack`, and the next type appears in the following cycle.
- R3: When `ping_evt` arrives in idle with `flt_adapter` or `flt_ctrl_high` set, the block skips the start-up packets. In the next cycle it requests type 5 (end transfer) with reason 0x00 if the adapter flag is set, otherwise reason 0x01.
- R4: After type 3 is acknowledged, the block requests type 4 (handshake). After that request is acknowledged, `hs_reply` seen while waiting sets `mode_hp` to 1 and enters active transfer in the next cycle.
- R5: If `hs_reply` has not arrived after HS_TIMEOUT waiting cycles, active transfer starts with `mode_hp` at 0. A reply in the last waiting cycle still gives `mode_hp` = 1.
- R6: In active transfer, `out_en` is 1 and no packet is requested. The fault flags map to reason codes as follows: adapter 0x00, control high 0x01, die over-temperature or limit resistor too low 0x02, hot sensor 0x03, non-converging overvoltage 0x04.
- R7: When several fault flags are set in the same cycle, the lowest reason code is reported.
- R8: A fault seen in active transfer drops `out_en` in the next cycle. The type-5 request rises one cycle after that, so the output is always off before the end packet is requested.
- R9: After the type-5 request is acknowledged, the block returns to idle. It stays there, ignoring faults, `pkt_ack` and `hs_reply`, until a new `ping_evt`. Outside idle, `ping_evt` has no effect.
- R10: Accepting a new ping clears `mode_hp` to 0 in the next cycle. `mode_hp` stays unchanged throughout active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ping_evt | input | 1 | Digital ping detected (one-cycle pulse) |
| pkt_ack | input | 1 | Modulator has sent the requested packet |
| hs_reply | input | 1 | Transmitter answered the high-power handshake |
| flt_adapter | input | 1 | Wired adapter present above threshold |
| flt_ctrl_high | input | 1 | Control pin high (charge complete) |
| flt_die_hot | input | 1 | Die over-temperature |
| flt_rlim_low | input | 1 | Current-limit resistor below minimum |
| flt_ntc_hot | input | 1 | External sensor reports hot |
| flt_ovp | input | 1 | Rectifier overvoltage not converging |
| pkt_req | output | 1 | Packet request pending |
| pkt_kind | output | 3 | Requested packet type (1..5) |
| reason | output | 8 | End-transfer reason byte, 0x00 unless type 5 is requested |
| mode_hp | output | 1 | Power mode status: 0 low power, 1 high power |
| out_en | output | 1 | Output stage enable |

## Verification
The bench builds the block with HS_TIMEOUT set to 8. At that value the handshake fallback is reached within a few cycles, so the bench can cover both the timeout path and a reply that lands exactly on the last waiting cycle. The bench also delays acknowledgements for several cycles, which exercises request holding. Simultaneous fault combinations are driven to cover the priority order, and both start-up bypass causes are tested.

// File: rtl/wpt_contract_seq.sv
module wpt_contract_seq #(
  parameter int HS_TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ping_evt,
  input  logic       pkt_ack,
  input  logic       hs_reply,
  input  logic       flt_adapter,
  input  logic       flt_ctrl_high,
  input  logic       flt_die_hot,
  input  logic       flt_rlim_low,
  input  logic       flt_ntc_hot,
  input  logic       flt_ovp,
  output logic       pkt_req,
  output logic [2:0] pkt_kind,
  output logic [7:0] reason,
  output logic       mode_hp,
  output logic       out_en
);

  localparam int CW = (HS_TIMEOUT > 1) ? $clog2(HS_TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(HS_TIMEOUT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SIG, S_CFG, S_ID, S_HSK, S_WAIT, S_ACT, S_STOP, S_EPT
  } state_t;

  state_t          state, nxt;
  logic [CW-1:0]   cnt;
  logic [7:0]      rsn_q, fault_code;
  logic            mode_q, any_fault, boot_stop;

  assign any_fault = flt_adapter | flt_ctrl_high | flt_die_hot |
                     flt_rlim_low | flt_ntc_hot | flt_ovp;
  assign boot_stop = flt_adapter | flt_ctrl_high;

  always_comb begin
    if (flt_adapter)                      fault_code = 8'h00;
    else if (flt_ctrl_high)               fault_code = 8'h01;
    else if (flt_die_hot | flt_rlim_low)  fault_code = 8'h02;
    else if (flt_ntc_hot)                 fault_code = 8'h03;
    else                                  fault_code = 8'h04;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (ping_evt) nxt = boot_stop ? S_EPT : S_SIG;
      S_SIG:  if (pkt_ack) nxt = S_CFG;
      S_CFG:  if (pkt_ack) nxt = S_ID;
      S_ID:   if (pkt_ack) nxt = S_HSK;
      S_HSK:  if (pkt_ack) nxt = S_WAIT;
      S_WAIT: if (hs_reply || cnt == LAST) nxt = S_ACT;
      S_ACT:  if (any_fault) nxt = S_STOP;
      S_STOP: nxt = S_EPT;
      S_EPT:  if (pkt_ack) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rsn_q  <= 8'h00;
      mode_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && ping_evt) begin
        mode_q <= 1'b0;
        if (boot_stop) rsn_q <= fault_code;
      end
      if (state == S_HSK)
        cnt <= '0;
      else if (state == S_WAIT && !hs_reply && cnt != LAST)
        cnt <= cnt + 1'b1;
      if (state == S_WAIT && hs_reply) mode_q <= 1'b1;
      if (state == S_ACT && any_fault) rsn_q <= fault_code;
    end
  end

  always_comb begin
    unique case (state)
      S_SIG:   pkt_kind = 3'd1;
      S_CFG:   pkt_kind = 3'd2;
      S_ID:    pkt_kind = 3'd3;
      S_HSK:   pkt_kind = 3'd4;
      S_EPT:   pkt_kind = 3'd5;
      default: pkt_kind = 3'd0;
    endcase
  end

  assign pkt_req = (pkt_kind != 3'd0);
  assign reason  = (state == S_EPT) ? rsn_q : 8'h00;
  assign mode_hp = mode_q;
  assign out_en  = (state == S_ACT);

endmodule

// File: rtl/wpt_contract_seq_chk.sv
module wpt_contract_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_ack,
  input logic       pkt_req,
  input logic [2:0] pkt_kind,
  input logic [7:0] reason,
  input logic       mode_hp,
  input logic       out_en
);

  a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && !pkt_ack |=> pkt_req && $stable(pkt_kind) && $stable(reason));

  a_r2_sig_then_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && pkt_ack && pkt_kind == 3'd1 |=> pkt_req && pkt_kind == 3'd2);

  a_r2_cfg_then_id: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && pkt_ack && pkt_kind == 3'd2 |=> pkt_req && pkt_kind == 3'd3);

  a_r6_no_req_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !pkt_req);

  a_r6_reason_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && pkt_kind == 3'd5 |-> reason <= 8'h04);

  a_r8_off_before_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_req) && pkt_kind == 3'd5 |-> !out_en && !$past(out_en));

  a_r10_mode_stable_on: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && $past(out_en) |-> $stable(mode_hp));

  a_r9_end_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && pkt_ack && pkt_kind == 3'd5 |=> !pkt_req && !out_en);

endmodule

bind wpt_contract_seq wpt_contract_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_ack(pkt_ack), .pkt_req(pkt_req),
  .pkt_kind(pkt_kind), .reason(reason), .mode_hp(mode_hp), .out_en(out_en)
);

// File: tb/wpt_contract_seq_bench.sv
module wpt_contract_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ping_evt = 0, pkt_ack = 0, hs_reply = 0;
  logic f_ad = 0, f_ch = 0, f_dh = 0, f_rl = 0, f_nh = 0, f_ov = 0;
  logic       pkt_req, mode_hp, out_en;
  logic [2:0] pkt_kind;
  logic [7:0] reason;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  int ph = 0, wcnt = 0, m_mode = 0, m_rsn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpt_contract_seq #(.HS_TIMEOUT(TO)) u_wpt_contract_seq (
    .clk(clk), .rst_n(rst_n), .ping_evt(ping_evt), .pkt_ack(pkt_ack),
    .hs_reply(hs_reply), .flt_adapter(f_ad), .flt_ctrl_high(f_ch),
    .flt_die_hot(f_dh), .flt_rlim_low(f_rl), .flt_ntc_hot(f_nh), .flt_ovp(f_ov),
    .pkt_req(pkt_req), .pkt_kind(pkt_kind), .reason(reason),
    .mode_hp(mode_hp), .out_en(out_en)
  );

  function automatic int prio();
    if (f_ad) return 0;
    if (f_ch) return 1;
    if (f_dh || f_rl) return 2;
    if (f_nh) return 3;
    return 4;
  endfunction

  task automatic model_step();
    case (ph)
      0: if (ping_evt) begin
           m_mode = 0;
           if (f_ad || f_ch) begin m_rsn = f_ad ? 0 : 1; ph = 8; end
           else ph = 1;
         end
      1, 2, 3: if (pkt_ack) ph = ph + 1;
      4: if (pkt_ack) begin ph = 5; wcnt = 0; end
      5: if (hs_reply) begin m_mode = 1; ph = 6; end
         else if (wcnt == TO - 1) begin m_mode = 0; ph = 6; end
         else wcnt++;
      6: if (f_ad || f_ch || f_dh || f_rl || f_nh || f_ov) begin
           m_rsn = prio(); ph = 7;
         end
      7: ph = 8;
      8: if (pkt_ack) ph = 0;
      default: ph = 0;
    endcase
  endtask

  task automatic compare();
    int ek, er;
    bit eq;
    ek = (ph >= 1 && ph <= 4) ? ph : (ph == 8 ? 5 : 0);
    er = (ph == 8) ? m_rsn : 0;
    checks++;
    eq = (pkt_req == (ek != 0)) && (int'(pkt_kind) == ek) && (int'(reason) == er)
         && (int'(mode_hp) == m_mode) && (out_en == (ph == 6));
    if (!eq) begin
      errors++;
      $display("FAIL %s cycle %0d: actual req=%0b kind=%0d reason=%0h mode=%0b en=%0b expected req=%0b kind=%0d reason=%0h mode=%0d en=%0b",
               tag, cyc, pkt_req, pkt_kind, reason, mode_hp, out_en,
               ek != 0, ek, er, m_mode, ph == 6);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_step();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_ping();
    ping_evt = 1; step(); ping_evt = 0;
  endtask

  task automatic ack_after(int d);
    steps(d); pkt_ack = 1; step(); pkt_ack = 0;
  endtask

  task automatic clr_faults();
    f_ad = 0; f_ch = 0; f_dh = 0; f_rl = 0; f_nh = 0; f_ov = 0;
  endtask

  task automatic startup_to_wait();
    pulse_ping();
    ack_after(2); ack_after(0); ack_after(3);
    ack_after(1);
  endtask

  task automatic finish_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_all();
  end

  initial begin
    tag = "R1";
    @(negedge clk); compare();
    steps(3);
    rst_n = 1;
    steps(3);

    tag = "R9";
    pkt_ack = 1; hs_reply = 1; f_ov = 1; f_nh = 1; steps(3);
    pkt_ack = 0; hs_reply = 0; clr_faults(); steps(2);

    tag = "R2";
    pulse_ping();
    ack_after(4); ack_after(1); ack_after(2);
    tag = "R4";
    ack_after(2);
    steps(3); hs_reply = 1; step(); hs_reply = 0;
    tag = "R6";
    steps(4);
    tag = "R9";
    ping_evt = 1; step(); ping_evt = 0;
    tag = "R6";
    f_nh = 1; step(); clr_faults();
    tag = "R8";
    steps(3); ack_after(0);
    tag = "R9";
    steps(5);

    tag = "R10";
    pulse_ping();
    tag = "R5";
    ack_after(0); ack_after(0); ack_after(0); ack_after(0);
    steps(TO + 2);
    tag = "R6";
    f_ov = 1; step(); clr_faults();
    steps(2); ack_after(1);

    tag = "R5";
    startup_to_wait();
    steps(TO - 1); hs_reply = 1; step(); hs_reply = 0;
    tag = "R7";
    f_dh = 1; f_nh = 1; f_ov = 1; step(); clr_faults();
    steps(2); ack_after(0);

    startup_to_wait();
    steps(TO + 1);
    f_rl = 1; f_ov = 1; step(); clr_faults();
    steps(1); ack_after(0);

    startup_to_wait();
    hs_reply = 1; step(); hs_reply = 0;
    f_ch = 1; f_ov = 1; f_dh = 1; step(); clr_faults();
    steps(1); ack_after(2);

    startup_to_wait();
    steps(TO + 1);
    f_ad = 1; f_ch = 1; step(); clr_faults();
    steps(1); ack_after(0);

    tag = "R3";
    f_ad = 1; f_ch = 1; pulse_ping(); clr_faults();
    steps(2); ack_after(0);
    f_ch = 1; pulse_ping(); clr_faults();
    steps(1); ack_after(1);
    tag = "R9";
    steps(4);

    finish_all();
  end
endmodule